// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Block

This block gives a multi-core chip a small set of registers through which any core can signal another core, or an external host, and tag that signal with the identity of the sender. Each destination has a sticky field of 28 source flags. A sender sets its own flag, and optionally the generate bit, by writing the destination's generation register. The generate bit produces a single-cycle interrupt pulse. The receiver reads the flags to learn who called. It then retires each flag by writing a one to the same bit position of the destination's acknowledgment register.

There are `N_CORES` core destinations plus one host destination, whose pulse drives a device pin. Each core also has an NMI register whose only effect is a one-cycle non-maskable pulse to that core. Access is through a single synchronous register port with word-aligned byte addresses. Read data is registered.

Top module: `ipi_regblock`

## Requirements
- R1: While `rst_n` is low, and after reset, all source flags are 0. `irq_core`, `nmi_core` and `irq_host` are low, and `reg_rdata` is 0.
- R2: A write to core i's generation register with bit 0 set drives `irq_core[i]` high for exactly the one cycle after the write. No other pulse output moves.
- R3: Bit 0 of generation and NMI registers is self-clearing. Bits 3:0 of every register read as 0.
- R4: In a generation register, bits 31:4 are write-1-to-set: bit 4+k is source flag k. Zero bits have no effect, so flags from several writers accumulate.
- R5: Bits 31:4 of an acknowledgment register read the same flags as bits 31:4 of the matching generation register.
- R6: A one in bit 4+k of an acknowledgment register write clears flag k of that destination. Zero bits and bits 3:0 have no effect. Acknowledgment writes never produce a pulse.
- R7: The host generation/acknowledgment pair behaves as R2 to R6, with the pulse on `irq_host`.
- R8: A write with bit 0 set to core i's NMI register pulses `nmi_core[i]` for exactly the cycle after the write. It leaves all source flags and `irq_core` unchanged, and the NMI register reads as 0.
- R9: The address map uses word index w = `reg_addr`/4:
  - w = i: generation register for core i.
  - w = N_CORES+i: acknowledgment register for core i.
  - w = 2·N_CORES+i: NMI register for core i.
  - w = 3·N_CORES: host generation register.
  - w = 3·N_CORES+1: host acknowledgment register.
  - Any other word, and any address with nonzero bits 1:0, reads 0 and ignores writes.
- R10: `reg_rdata` takes the addressed register's value at the clock edge where `reg_rd_en` is high. It holds that value while `reg_rd_en` is low.
- R11: A generation write with bit 0 clear updates the flags but produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_core | output | N_CORES | Interrupt pulse, one per core |
| nmi_core | output | N_CORES | Non-maskable interrupt pulse, one per core |
| irq_host | output | 1 | Host interrupt pin pulse |

## Verification
The flag logic is exercised with several write patterns:
- Single-bit sets, and a set followed by a write of zeros, which separate write-1-to-set from plain overwrite.
- All-ones writes to a generation register, which expose leakage into reserved bits 3:0 and into the self-clearing generate bit.
- Acknowledgment writes that mix cleared and kept bits, including the extreme flags 0 and 27, which tell a per-bit clear from a whole-register clear.

Pulse behaviour is checked on generate writes with and without bit 0, on NMI writes, and on acknowledgment writes. These separate a real pulse from one produced by any write to the register. Unmapped and misaligned addresses, and a reset during activity, complete the set.

// File: rtl/ipi_pkg.sv
// Shared constants and types for the inter-processor interrupt block.
// Assumes a 32-bit register word with the source flags in the upper 28 bits.
package ipi_pkg;
    localparam int REG_W    = 32;
    localparam int FLAG_LSB = 4;
    localparam int NUM_SRC  = REG_W - FLAG_LSB;
    localparam int FIRE_BIT = 0;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_GEN  = 2'd1,
        RK_ACK  = 2'd2,
        RK_NMI  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/ipi_addr_decode.sv
// Address decoder: maps a byte address onto register kind and destination
// index, and produces one write enable per register.
// Assumes word-aligned access; a misaligned address selects nothing.
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ADDR_W  = 8,
    localparam int N_DEST = N_CORES + 1,
    localparam int IDX_W  = $clog2(N_DEST)
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    output reg_kind_e         sel_kind,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [N_DEST-1:0] gen_we,
    output logic [N_DEST-1:0] ack_we,
    output logic [N_CORES-1:0] nmi_we
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    int unsigned       w;

    assign word = reg_addr[ADDR_W-1:2];

    // Classify the addressed word into a register kind and destination index.
    always_comb begin
        w        = 32'(word);
        sel_kind = RK_NONE;
        sel_idx  = '0;
        if (reg_addr[1:0] != 2'b00) begin
            sel_kind = RK_NONE;
        end else if (w < N_CORES) begin
            sel_kind = RK_GEN;
            sel_idx  = IDX_W'(w);
        end else if (w < 2 * N_CORES) begin
            sel_kind = RK_ACK;
            sel_idx  = IDX_W'(w - N_CORES);
        end else if (w < 3 * N_CORES) begin
            sel_kind = RK_NMI;
            sel_idx  = IDX_W'(w - 2 * N_CORES);
        end else if (w == 3 * N_CORES) begin
            sel_kind = RK_GEN;
            sel_idx  = IDX_W'(N_CORES);
        end else if (w == 3 * N_CORES + 1) begin
            sel_kind = RK_ACK;
            sel_idx  = IDX_W'(N_CORES);
        end
    end

    // One write enable per destination for generation and acknowledgment.
    for (genvar b = 0; b < N_DEST; b++) begin : g_dest_we
        assign gen_we[b] = reg_wr_en && (sel_kind == RK_GEN) && (sel_idx == IDX_W'(b));
        assign ack_we[b] = reg_wr_en && (sel_kind == RK_ACK) && (sel_idx == IDX_W'(b));
    end

    // One write enable per core NMI register.
    for (genvar c = 0; c < N_CORES; c++) begin : g_nmi_we
        assign nmi_we[c] = reg_wr_en && (sel_kind == RK_NMI) && (sel_idx == IDX_W'(c));
    end
endmodule

// File: rtl/ipi_pulse.sv
// Single-cycle pulse register: the output is high for exactly the cycle
// after fire was sampled high. Assumes fire is already qualified.
module ipi_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    // Register the request so the pulse is one clock wide and self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= fire;
    end
endmodule

// File: rtl/ipi_flag_bank.sv
// One destination: sticky source flags plus its interrupt pulse.
// Flags are set by generation writes and cleared by acknowledgment writes.
// Assumes at most one of gen_we/ack_we per cycle; if both arrive, set wins.
module ipi_flag_bank
    import ipi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_we,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] wr_flags,
    input  logic               wr_fire,
    output logic [NUM_SRC-1:0] flags,
    output logic               irq
);
    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] clr_mask;

    assign set_mask = gen_we ? wr_flags : '0;
    assign clr_mask = ack_we ? wr_flags : '0;

    // Sticky flag update: clear first, then set, so a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_mask;
    end

    ipi_pulse u_irq_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (gen_we && wr_fire),
        .pulse (irq)
    );
endmodule

// File: rtl/ipi_regblock.sv
// Inter-processor interrupt register block (top). Holds N_CORES+1 flag
// banks (the last one serves the host pin) and N_CORES NMI pulse generators
// behind a single synchronous register port with registered read data.
// Assumes ADDR_W is wide enough for 3*N_CORES+2 words.
module ipi_regblock
    import ipi_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [N_CORES-1:0] irq_core,
    output logic [N_CORES-1:0] nmi_core,
    output logic               irq_host
);
    localparam int N_DEST = N_CORES + 1;
    localparam int IDX_W  = $clog2(N_DEST);

    reg_kind_e          sel_kind;
    logic [IDX_W-1:0]   sel_idx;
    logic [N_DEST-1:0]  gen_we;
    logic [N_DEST-1:0]  ack_we;
    logic [N_CORES-1:0] nmi_we;
    logic [NUM_SRC-1:0] bank_flags [N_DEST];
    logic [N_DEST-1:0]  bank_irq;
    logic [NUM_SRC-1:0] wr_flags;
    logic               wr_fire;
    logic [REG_W-1:0]   rd_word;
    logic               unused_rsvd_wdata;

    assign wr_flags          = reg_wdata[REG_W-1:FLAG_LSB];
    assign wr_fire           = reg_wdata[FIRE_BIT];
    assign unused_rsvd_wdata = ^reg_wdata[FLAG_LSB-1:FIRE_BIT+1];

    ipi_addr_decode #(
        .N_CORES (N_CORES),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .sel_kind  (sel_kind),
        .sel_idx   (sel_idx),
        .gen_we    (gen_we),
        .ack_we    (ack_we),
        .nmi_we    (nmi_we)
    );

    // Flag banks: one per core, plus the host bank at index N_CORES.
    for (genvar b = 0; b < N_DEST; b++) begin : g_bank
        ipi_flag_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_we   (gen_we[b]),
            .ack_we   (ack_we[b]),
            .wr_flags (wr_flags),
            .wr_fire  (wr_fire),
            .flags    (bank_flags[b]),
            .irq      (bank_irq[b])
        );
    end

    // NMI pulse generators, one per core.
    for (genvar c = 0; c < N_CORES; c++) begin : g_nmi
        ipi_pulse u_nmi_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (nmi_we[c] && wr_fire),
            .pulse (nmi_core[c])
        );
    end

    assign irq_core = bank_irq[N_CORES-1:0];
    assign irq_host = bank_irq[N_CORES];

    // Read mux: generation and acknowledgment both show the flags; all else is 0.
    always_comb begin
        rd_word = '0;
        if ((sel_kind == RK_GEN || sel_kind == RK_ACK) && (32'(sel_idx) < N_DEST))
            rd_word = {bank_flags[sel_idx], {FLAG_LSB{1'b0}}};
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_word;
    end
endmodule

// File: rtl/ipi_regblock_chk.sv
// Checker for ipi_regblock: port-level timing properties of the pulses,
// reserved read bits and reset state. Attached through bind below.
module ipi_regblock_chk #(
    parameter int N_CORES = 4,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [N_CORES-1:0] irq_core,
    input logic [N_CORES-1:0] nmi_core,
    input logic               irq_host
);
    localparam int HOST_GEN = 4 * (3 * N_CORES);
    localparam int HOST_ACK = HOST_GEN + 4;

    logic seen_edge = 1'b0;
    logic ack_hit;

    // Marks that at least one clock edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // True when the port is writing any acknowledgment register.
    always_comb begin
        ack_hit = 1'b0;
        for (int i = 0; i < N_CORES; i++)
            if (reg_addr == ADDR_W'(4 * (N_CORES + i))) ack_hit = 1'b1;
        if (reg_addr == ADDR_W'(HOST_ACK)) ack_hit = 1'b1;
        ack_hit = ack_hit && reg_wr_en;
    end

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        assert_core_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
            irq_core[i] |-> $past(reg_wr_en && reg_addr == ADDR_W'(4 * i) && reg_wdata[0]));
        assert_nmi_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_core[i] |-> $past(reg_wr_en && reg_addr == ADDR_W'(4 * (2 * N_CORES + i)) && reg_wdata[0]));
    end

    assert_host_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_host |-> $past(reg_wr_en && reg_addr == ADDR_W'(HOST_GEN) && reg_wdata[0]));

    assert_ack_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (irq_core == '0 && !irq_host));

    assert_rsvd_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd_en) |-> reg_rdata[3:0] == 4'h0);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        (seen_edge && $past(!rst_n)) |-> (irq_core == '0 && nmi_core == '0 && !irq_host && reg_rdata == '0));
endmodule

bind ipi_regblock ipi_regblock_chk #(
    .N_CORES (N_CORES),
    .ADDR_W  (ADDR_W)
) u_ipi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_core  (irq_core),
    .nmi_core  (nmi_core),
    .irq_host  (irq_host)
);

// File: tb/test_ipi_regblock.sv
`timescale 1ns/1ps
module test_ipi_regblock;
    localparam int N_CORES = 4;
    localparam int ADDR_W  = 8;
    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;
    localparam int NV = 24;

    // {op, addr, wdata, expected read data}
    localparam logic [73:0] VEC [NV] = '{
        {OP_WR, 8'h04, 32'h0000_0021, 32'h0},          // R4 set flag1 on core1
        {OP_RD, 8'h04, 32'h0,         32'h0000_0020},  // R3 R4 fire bit reads 0
        {OP_RD, 8'h14, 32'h0,         32'h0000_0020},  // R5 ack mirrors
        {OP_WR, 8'h04, 32'h0000_0100, 32'h0},          // R4 add flag4
        {OP_RD, 8'h04, 32'h0,         32'h0000_0120},  // R4 accumulate
        {OP_WR, 8'h04, 32'h0000_0000, 32'h0},          // R4 zeros no effect
        {OP_RD, 8'h04, 32'h0,         32'h0000_0120},  // R4
        {OP_WR, 8'h14, 32'h0000_0020, 32'h0},          // R6 clear flag1
        {OP_RD, 8'h04, 32'h0,         32'h0000_0100},  // R6 gen side cleared
        {OP_RD, 8'h14, 32'h0,         32'h0000_0100},  // R5 R6 ack side
        {OP_WR, 8'h14, 32'h0000_000F, 32'h0},          // R6 low ack bits ignored
        {OP_RD, 8'h04, 32'h0,         32'h0000_0100},  // R6
        {OP_WR, 8'h0C, 32'hFFFF_FFFF, 32'h0},          // R3 R4 all ones on core3
        {OP_RD, 8'h0C, 32'h0,         32'hFFFF_FFF0},  // R3
        {OP_RD, 8'h00, 32'h0,         32'h0000_0000},  // R9 core0 untouched
        {OP_WR, 8'h1C, 32'h8000_0010, 32'h0},          // R6 clear flags 27 and 0
        {OP_RD, 8'h1C, 32'h0,         32'h7FFF_FFE0},  // R6 extremes
        {OP_WR, 8'h30, 32'h0000_0041, 32'h0},          // R7 host flag2
        {OP_RD, 8'h34, 32'h0,         32'h0000_0040},  // R7 host ack mirror
        {OP_RD, 8'h20, 32'h0,         32'h0000_0000},  // R8 NMI reads 0
        {OP_WR, 8'h38, 32'hFFFF_FFFF, 32'h0},          // R9 unmapped write
        {OP_RD, 8'h38, 32'h0,         32'h0000_0000},  // R9 unmapped read
        {OP_WR, 8'h34, 32'h0000_0040, 32'h0},          // R7 host ack clear
        {OP_RD, 8'h30, 32'h0,         32'h0000_0000}   // R7
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr_en;
    logic               reg_rd_en;
    logic [ADDR_W-1:0]  reg_addr;
    logic [31:0]        reg_wdata;
    logic [31:0]        reg_rdata;
    logic [N_CORES-1:0] irq_core;
    logic [N_CORES-1:0] nmi_core;
    logic               irq_host;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    ipi_regblock #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) i_ipi_regblock (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_core(irq_core), .nmi_core(nmi_core), .irq_host(irq_host)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] pulses();
        return {23'd0, irq_host, nmi_core, irq_core};
    endfunction

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 pulses in reset", pulses(), 32'h0);
        check("R1 rdata in reset", reg_rdata, 32'h0);
        rst_n = 1'b1;
        do_read(8'h00, rd);
        check("R1 flags after reset", rd, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][73:72] == OP_WR) begin
                do_write(VEC[k][71:64], VEC[k][63:32]);
            end else begin
                do_read(VEC[k][71:64], rd);
                check($sformatf("vector %0d read", k), rd, VEC[k][31:0]);
            end
        end

        // R2: generate on core2 pulses irq_core[2] for one cycle only
        do_write(8'h08, 32'h0000_0001);
        check("R2 pulse cycle", pulses(), 32'h0000_0004);
        @(negedge clk);
        check("R2 pulse width", pulses(), 32'h0);

        // R11: flags without fire give no pulse
        do_write(8'h08, 32'h0000_0010);
        check("R11 no pulse", pulses(), 32'h0);
        do_read(8'h08, rd);
        check("R11 flag set", rd, 32'h0000_0010);

        // R8: NMI on core2 pulses nmi_core[2] only and leaves flags alone
        do_write(8'h28, 32'hFFFF_FFFF);
        check("R8 nmi pulse", pulses(), 32'h0000_0040);
        @(negedge clk);
        check("R8 nmi width", pulses(), 32'h0);
        do_read(8'h08, rd);
        check("R8 flags unchanged", rd, 32'h0000_0010);

        // R7: host generate pulses irq_host for one cycle
        do_write(8'h30, 32'h0000_0001);
        check("R7 host pulse", pulses(), 32'h0000_0100);
        @(negedge clk);
        check("R7 host width", pulses(), 32'h0);

        // R6: acknowledgment with bit 0 set gives no pulse
        do_write(8'h18, 32'h0000_0011);
        check("R6 ack no pulse", pulses(), 32'h0);
        do_read(8'h08, rd);
        check("R6 flag cleared", rd, 32'h0);

        // R9: misaligned write is ignored
        do_write(8'h09, 32'h0000_0101);
        check("R9 misaligned no pulse", pulses(), 32'h0);
        do_read(8'h08, rd);
        check("R9 misaligned ignored", rd, 32'h0);

        // R10: rdata holds while no read strobe
        do_read(8'h04, rd);
        check("R10 read core1", rd, 32'h0000_0100);
        do_write(8'h04, 32'h0000_0200);
        repeat (2) @(negedge clk);
        check("R10 rdata held", reg_rdata, 32'h0000_0100);
        do_read(8'h04, rd);
        check("R10 fresh read", rd, 32'h0000_0300);

        // R1: reset in mid-operation clears flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset quiet", pulses(), 32'h0);
        rst_n = 1'b1;
        do_read(8'h04, rd);
        check("R1 flags cleared", rd, 32'h0);
        do_read(8'h0C, rd);
        check("R1 core3 cleared", rd, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule